// File: doc/BRIEF.md
# Film Dot Grid Byte Extractor

This block turns one decoded film code, a square grid of one-bit dots 76 wide and 76 tall, into a stream of payload bytes. Rows of the grid arrive one per input beat, 76 bits wide, and the first row of every code is marked with a start pulse. The block gathers four rows into a band. It then walks the band from left to right in steps of two columns. Each 2-wide by 4-tall tile becomes one byte, unless the tile lies in a reserved area: one of the four 8 by 8 registration squares in the corners, or the 12 by 12 logo square in the middle.

Bytes leave on a valid/ready port and carry first-byte and last-byte markers. A flag on every byte of a code tells whether that code is the periodic special one, which is every 44th code counted since reset. Two sticky error flags are provided. The first reports a start pulse that arrives while a code is still in progress. The second reports a code that ended or was cut short with a byte count other than 672. A clear input resets both flags. Input is held off while a band drains, and a code needs far fewer cycles than the frame rate allows.

Top module: `fx_byte_extractor`

## Requirements
- R1: `in_ready` is high while rows are being collected. It drops in the cycle after the fourth row of a band is accepted and stays low until every tile of that band has been handled.
- R2: Byte bit i, for i from 0 to 3, is the dot at row 4b+i and column 2t. Bit 4+i is the dot at row 4b+i and column 2t+1. Here b is the band and t is the tile, and column c of a row is carried on `in_row[c]`.
- R3: Tiles whose dots fall in rows 0-7 or 68-75 and also in columns 0-7 or 68-75 give no byte. Tiles in rows 32-43 and also in columns 32-43 give no byte. The dot values in those areas have no effect on the output.
- R4: Bytes leave with bands in ascending order and, within a band, tiles in ascending order. A complete code gives exactly 672 bytes.
- R5: `out_sof` is high on the first byte of a code only, and `out_eof` is high on its last byte only.
- R6: While `out_valid` is high and `out_ready` is low, the byte and its flags stay unchanged.
- R7: Tiles are examined one per cycle. A reserved tile takes one cycle and produces no output, so the first byte of band 0 is offered four cycles after the band's first tile slot. The first byte of a band with no reserved leading tile is offered in the cycle right after its fourth row is accepted.
- R8: Every accepted start pulse advances a code counter modulo 44. `out_special` is high on all bytes of the 44th, 88th, ... code since reset and low on all bytes of the other codes.
- R9: A start pulse accepted while a code is in progress starts a new code at row 0, band 0, and sets the sticky flag `err_resync`.
- R10: `err_len` is set when a code completes with a byte count other than 672, or is cut short by a new start pulse. It stays low across complete codes.
- R11: A pulse on `err_clr` clears both `err_resync` and `err_len`. A new error in the same cycle wins over the clear.
- R12: Rows offered without a start pulse while no code is in progress are accepted and discarded.
- R13: After reset, `in_ready` is high and `out_valid`, `err_resync` and `err_len` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Row beat valid |
| in_ready | output | 1 | Block can take a row |
| in_sof | input | 1 | Row is row 0 of a new code |
| in_row | input | 76 | One grid row, bit c is column c |
| out_valid | output | 1 | Byte valid |
| out_ready | input | 1 | Sink takes the byte |
| out_data | output | 8 | Payload byte |
| out_sof | output | 1 | First byte of the code |
| out_eof | output | 1 | Last byte of the code |
| out_special | output | 1 | Byte belongs to a special code |
| err_clr | input | 1 | Clears both error flags |
| err_resync | output | 1 | Sticky: start pulse arrived mid-code |
| err_len | output | 1 | Sticky: code byte count was not 672 |

## Verification
Once a band's fourth row is accepted, tile t of that band is examined in the cycle t edges later, provided the sink is always ready. The bench therefore counts falling edges after the accepting edge. It expects the first band-0 byte on the fifth falling edge, the first band-2 byte on the first, and `in_ready` back on the 39th. All other results are compared by content and order from a byte log taken at falling edges whenever `out_valid` and `out_ready` are both high. This makes the checks independent of how back-pressure stretches the drain. Error flags are read only after the input has gone idle again.

// File: rtl/fx_pkg.sv
package fx_pkg;
    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_DRAIN = 1'b1
    } fx_state_e;
endpackage

// File: rtl/fx_tile_mask.sv
// Flags tiles that fall inside a corner square or the centre square.
module fx_tile_mask #(
    parameter int GRID    = 76,
    parameter int TILE_W  = 2,
    parameter int TILE_H  = 4,
    parameter int CORNER  = 8,
    parameter int LOGO_LO = 32,
    parameter int LOGO_SZ = 12,
    parameter int BW      = 5,
    parameter int TW      = 6
) (
    input  logic [BW-1:0] band,
    input  logic [TW-1:0] tile,
    output logic          reserved
);
    localparam int FAR  = GRID - CORNER;
    localparam int LOGO_HI = LOGO_LO + LOGO_SZ;

    int  row0;
    int  col0;
    logic row_edge;
    logic col_edge;
    logic row_mid;
    logic col_mid;

    always_comb begin
        row0     = int'(band) * TILE_H;
        col0     = int'(tile) * TILE_W;
        row_edge = (row0 < CORNER) || (row0 >= FAR);
        col_edge = (col0 < CORNER) || (col0 >= FAR);
        row_mid  = (row0 >= LOGO_LO) && (row0 < LOGO_HI);
        col_mid  = (col0 >= LOGO_LO) && (col0 < LOGO_HI);
        reserved = (row_edge && col_edge) || (row_mid && col_mid);
    end
endmodule

// File: rtl/fx_tile_gather.sv
// Assembles one byte from a tile: left column low bits, top to bottom.
module fx_tile_gather #(
    parameter int GRID   = 76,
    parameter int TILE_W = 2,
    parameter int TILE_H = 4,
    parameter int TW     = 6
) (
    input  logic [TILE_H-1:0][GRID-1:0] rows,
    input  logic [TW-1:0]               tile,
    output logic [TILE_W*TILE_H-1:0]    tile_byte
);
    int base;

    always_comb begin
        base      = int'(tile) * TILE_W;
        tile_byte = '0;
        for (int c = 0; c < TILE_W; c++) begin
            for (int r = 0; r < TILE_H; r++) begin
                tile_byte[c*TILE_H + r] = rows[r][base + c];
            end
        end
    end
endmodule

// File: rtl/fx_code_counter.sv
// Modulo-PERIOD count of started codes; is_last marks the special slot.
module fx_code_counter #(
    parameter int PERIOD = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic is_last
);
    localparam int CNTW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CNTW-1:0] cnt_d, cnt_q;

    always_comb begin
        is_last = (cnt_q == CNTW'(PERIOD - 1));
        cnt_d   = cnt_q;
        if (advance) begin
            cnt_d = is_last ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/fx_byte_extractor.sv
module fx_byte_extractor
    import fx_pkg::*;
#(
    parameter int GRID    = 76,
    parameter int TILE_W  = 2,
    parameter int TILE_H  = 4,
    parameter int CORNER  = 8,
    parameter int LOGO_LO = 32,
    parameter int LOGO_SZ = 12,
    parameter int PERIOD  = 44,
    localparam int BYTE_W = TILE_W * TILE_H
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_sof,
    input  logic [GRID-1:0]   in_row,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_special,
    input  logic              err_clr,
    output logic              err_resync,
    output logic              err_len
);
    localparam int BANDS     = GRID / TILE_H;
    localparam int TILES     = GRID / TILE_W;
    localparam int PAYLOAD   = GRID*GRID - 4*CORNER*CORNER - LOGO_SZ*LOGO_SZ;
    localparam int BYTES     = PAYLOAD / BYTE_W;
    localparam int LAST_TILE = TILES - 1 - CORNER / TILE_W;
    localparam int RW        = (TILE_H > 1) ? $clog2(TILE_H) : 1;
    localparam int BW        = $clog2(BANDS);
    localparam int TW        = $clog2(TILES);
    localparam int CW        = $clog2(BYTES + 1);

    typedef struct packed {
        fx_state_e                  state;
        logic [RW-1:0]              row_idx;
        logic [BW-1:0]              band;
        logic [TW-1:0]              tile;
        logic [TILE_H-1:0][GRID-1:0] rows;
        logic                       active;
        logic                       special;
        logic [CW-1:0]              byte_cnt;
        logic                       err_resync;
        logic                       err_len;
    } fx_state_t;

    fx_state_t st_d, st_q;

    logic              reserved;
    logic [BYTE_W-1:0] tile_byte;
    logic              code_last;
    logic              accept;
    logic              start;
    logic              step;
    logic [CW-1:0]     cnt_after;

    fx_tile_mask #(
        .GRID(GRID), .TILE_W(TILE_W), .TILE_H(TILE_H), .CORNER(CORNER),
        .LOGO_LO(LOGO_LO), .LOGO_SZ(LOGO_SZ), .BW(BW), .TW(TW)
    ) mask_i (
        .band     (st_q.band),
        .tile     (st_q.tile),
        .reserved (reserved)
    );

    fx_tile_gather #(
        .GRID(GRID), .TILE_W(TILE_W), .TILE_H(TILE_H), .TW(TW)
    ) gather_i (
        .rows      (st_q.rows),
        .tile      (st_q.tile),
        .tile_byte (tile_byte)
    );

    fx_code_counter #(
        .PERIOD(PERIOD)
    ) codes_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (start),
        .is_last (code_last)
    );

    // Port side of the state.
    always_comb begin
        in_ready    = (st_q.state == ST_FILL);
        out_valid   = (st_q.state == ST_DRAIN) && !reserved;
        out_data    = tile_byte;
        out_sof     = out_valid && (st_q.byte_cnt == '0);
        out_eof     = out_valid && (st_q.band == BW'(BANDS - 1))
                                && (st_q.tile == TW'(LAST_TILE));
        out_special = st_q.special;
        err_resync  = st_q.err_resync;
        err_len     = st_q.err_len;
    end

    // Next-state computation.
    always_comb begin
        st_d      = st_q;
        accept    = in_valid && (st_q.state == ST_FILL);
        start     = accept && in_sof;
        step      = (st_q.state == ST_DRAIN) && (reserved || out_ready);
        cnt_after = st_q.byte_cnt + CW'(!reserved);

        if (err_clr) begin
            st_d.err_resync = 1'b0;
            st_d.err_len    = 1'b0;
        end

        if (start) begin
            if (st_q.active) begin
                st_d.err_resync = 1'b1;
                if (st_q.byte_cnt != CW'(BYTES)) st_d.err_len = 1'b1;
            end
            st_d.rows[0]  = in_row;
            st_d.row_idx  = RW'(1);
            st_d.band     = '0;
            st_d.tile     = '0;
            st_d.active   = 1'b1;
            st_d.special  = code_last;
            st_d.byte_cnt = '0;
        end else if (accept && st_q.active) begin
            st_d.rows[st_q.row_idx] = in_row;
            if (st_q.row_idx == RW'(TILE_H - 1)) begin
                st_d.row_idx = '0;
                st_d.tile    = '0;
                st_d.state   = ST_DRAIN;
            end else begin
                st_d.row_idx = st_q.row_idx + 1'b1;
            end
        end

        if (step) begin
            st_d.byte_cnt = cnt_after;
            if (st_q.tile == TW'(TILES - 1)) begin
                st_d.tile  = '0;
                st_d.state = ST_FILL;
                if (st_q.band == BW'(BANDS - 1)) begin
                    st_d.band   = '0;
                    st_d.active = 1'b0;
                    if (cnt_after != CW'(BYTES)) st_d.err_len = 1'b1;
                end else begin
                    st_d.band = st_q.band + 1'b1;
                end
            end else begin
                st_d.tile = st_q.tile + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fx_extract_chk.sv
module fx_extract_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_sof,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_sof,
    input logic              out_eof,
    input logic              out_special,
    input logic              err_clr,
    input logic              err_resync,
    input logic              err_len
);
    // R1
    input_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R6
    stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
            $stable(out_sof) && $stable(out_eof) && $stable(out_special)));

    // R5
    marker_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof || out_eof) |-> (out_valid && !(out_sof && out_eof)));

    // R8
    special_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_sof) |-> $stable(out_special));

    // R9
    resync_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_resync && !err_clr) |=> err_resync);

    // R10
    len_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_len && !err_clr) |=> err_len);

    // R11
    resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(in_valid && in_sof)) |=> !err_resync);
endmodule

bind fx_byte_extractor fx_extract_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_sof      (in_sof),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_sof     (out_sof),
    .out_eof     (out_eof),
    .out_special (out_special),
    .err_clr     (err_clr),
    .err_resync  (err_resync),
    .err_len     (err_len)
);

// File: tb/fx_byte_extractor_tb_top.sv
`timescale 1ns/1ps
module fx_byte_extractor_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_sof = 1'b0;
    logic [75:0] in_row = '0;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_data;
    logic        out_sof, out_eof, out_special;
    logic        err_clr = 1'b0;
    logic        err_resync, err_len;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int codes_started = 0;
    bit bp = 1'b0;
    logic [31:0] rng = 32'h1badf00d;

    logic [75:0] grid [76];
    byte unsigned rx_data[$];
    bit rx_sof[$], rx_eof[$], rx_spec[$];

    always #10 clk = ~clk;

    assign out_ready = !bp || ((cyc % 3) != 0);

    fx_byte_extractor dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sof(in_sof), .in_row(in_row), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .out_special(out_special), .err_clr(err_clr),
        .err_resync(err_resync), .err_len(err_len)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            checks++; errors++;
            $display("FAIL R4 watchdog: got %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready) begin
            rx_data.push_back(out_data);
            rx_sof.push_back(out_sof);
            rx_eof.push_back(out_eof);
            rx_spec.push_back(out_special);
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic bit is_res(input int r, input int c);
        bit corner = (r < 8 || r >= 68) && (c < 8 || c >= 68);
        bit logo   = (r >= 32 && r < 44) && (c >= 32 && c < 44);
        return corner || logo;
    endfunction

    // kind 0: random, 1: reserved dots set and payload clear, 2: two single dots
    task automatic make_grid(input int kind);
        for (int r = 0; r < 76; r++) begin
            grid[r] = {nxt()[11:0], nxt(), nxt()};
            for (int c = 0; c < 76; c++) begin
                if (kind == 1) grid[r][c] = is_res(r, c);
                if (kind == 2) grid[r][c] = 1'b0;
            end
        end
        if (kind == 2) begin
            grid[9][1]  = 1'b1;
            grid[46][3] = 1'b1;
        end
    endtask

    task automatic clear_rx();
        rx_data.delete(); rx_sof.delete(); rx_eof.delete(); rx_spec.delete();
    endtask

    task automatic send_row(input logic [75:0] row, input bit sof);
        @(negedge clk);
        in_valid = 1'b1; in_row = row; in_sof = sof;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        #1;
        in_valid = 1'b0; in_sof = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic send_rows(input int first, input int last);
        for (int r = first; r <= last; r++) begin
            send_row(grid[r], r == 0);
            if (r == 0) codes_started++;
        end
    endtask

    task automatic check_code(input string tag);
        byte unsigned exp_q[$];
        int bad = 0, bad_idx = -1, sof_bad = 0, eof_bad = 0, spec_bad = 0;
        bit exp_spec = (codes_started % 44) == 0;
        for (int b = 0; b < 19; b++) begin
            for (int t = 0; t < 38; t++) begin
                if (!is_res(4*b, 2*t)) begin
                    byte unsigned v = 0;
                    for (int i = 0; i < 4; i++) begin
                        v[i]   = grid[4*b+i][2*t];
                        v[4+i] = grid[4*b+i][2*t+1];
                    end
                    exp_q.push_back(v);
                end
            end
        end
        chk(rx_data.size() == 672, "R4", {tag, " byte count"}, rx_data.size(), 672);
        for (int i = 0; i < rx_data.size() && i < exp_q.size(); i++) begin
            if (rx_data[i] != exp_q[i]) begin
                bad++;
                if (bad_idx < 0) bad_idx = i;
            end
            if (rx_sof[i] != (i == 0)) sof_bad++;
            if (rx_eof[i] != (i == rx_data.size() - 1)) eof_bad++;
            if (rx_spec[i] != exp_spec) spec_bad++;
        end
        chk(bad == 0, "R2", {tag, " mismatching bytes (order R4, mask R3)"}, bad, 0);
        chk(sof_bad == 0 && eof_bad == 0, "R5", {tag, " misplaced markers"},
            sof_bad + eof_bad, 0);
        chk(spec_bad == 0, "R8", {tag, " special flag wrong"}, spec_bad, 0);
        chk(err_len == 1'b0, "R10", {tag, " err_len after full code"}, err_len, 0);
    endtask

    task automatic t_reset();
        chk(in_ready == 1'b1, "R13", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R13", "out_valid after reset", out_valid, 0);
        chk(err_resync == 1'b0 && err_len == 1'b0, "R13", "error flags after reset",
            err_resync + err_len, 0);
    endtask

    task automatic t_plain();
        clear_rx(); make_grid(0); send_rows(0, 75); wait_idle();
        check_code("random code");
    endtask

    task automatic t_bit_order();
        clear_rx(); make_grid(2); send_rows(0, 75); wait_idle();
        chk(rx_data.size() > 385 && rx_data[60] == 8'h20, "R2",
            "dot row9 col1 -> band2 tile0 bit5", rx_data.size() > 60 ? rx_data[60] : -1, 32);
        chk(rx_data.size() > 385 && rx_data[385] == 8'h40, "R2",
            "dot row46 col3 -> band11 tile1 bit6", rx_data.size() > 385 ? rx_data[385] : -1, 64);
        check_code("two-dot code");
    endtask

    task automatic t_reserved();
        int nz = 0;
        clear_rx(); make_grid(1); send_rows(0, 75); wait_idle();
        foreach (rx_data[i]) if (rx_data[i] != 0) nz++;
        chk(nz == 0, "R3", "bytes touched by reserved dots", nz, 0);
        check_code("reserved-only code");
    endtask

    task automatic t_latency();
        bit v[7];
        int n;
        clear_rx(); make_grid(0);
        send_rows(0, 3);
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk);
            v[k] = out_valid;
            if (k == 1) chk(in_ready == 1'b0, "R1", "in_ready after band fill", in_ready, 0);
        end
        chk(v[4] == 1'b0 && v[5] == 1'b1, "R7", "band0 first byte at 5th falling edge",
            {v[4], v[5]}, 1);
        wait_idle();
        send_rows(4, 11);
        @(negedge clk);
        chk(out_valid == 1'b1, "R7", "band2 first byte at 1st falling edge", out_valid, 1);
        n = 1;
        while (!in_ready && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == 39, "R1", "band2 in_ready back at falling edge", n, 39);
        send_rows(12, 75); wait_idle();
        check_code("latency code");
    endtask

    task automatic t_backpressure();
        clear_rx(); make_grid(0); bp = 1'b1;
        send_rows(0, 75); wait_idle();
        bp = 1'b0;
        check_code("back-pressured code (R6)");
    endtask

    task automatic t_drop();
        clear_rx(); make_grid(0);
        for (int r = 0; r < 8; r++) send_row(grid[r], 1'b0);
        repeat (5) @(negedge clk);
        chk(rx_data.size() == 0, "R12", "bytes from rows outside a code", rx_data.size(), 0);
        chk(in_ready == 1'b1, "R12", "in_ready after stray rows", in_ready, 1);
        t_plain();
    endtask

    task automatic t_resync();
        clear_rx(); make_grid(0);
        send_rows(0, 9); wait_idle();
        chk(err_resync == 1'b0, "R9", "err_resync before restart", err_resync, 0);
        clear_rx(); make_grid(0);
        send_rows(0, 75); wait_idle();
        chk(err_resync == 1'b1, "R9", "err_resync after restart", err_resync, 1);
        chk(err_len == 1'b1, "R10", "err_len after cut-short code", err_len, 1);
        chk(rx_data.size() == 672, "R9", "restarted code byte count", rx_data.size(), 672);
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk(err_resync == 1'b0 && err_len == 1'b0, "R11", "flags after clear",
            err_resync + err_len, 0);
    endtask

    task automatic t_special();
        while (codes_started < 45) begin
            clear_rx(); make_grid(0); send_rows(0, 75); wait_idle();
            if (codes_started >= 43) check_code($sformatf("code %0d", codes_started));
            else chk(rx_spec.size() == 672 && rx_spec[0] == 1'b0, "R8",
                     "special flag on ordinary code", rx_spec.size() > 0 ? rx_spec[0] : -1, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain();
        t_bit_order();
        t_reserved();
        t_latency();
        t_backpressure();
        t_drop();
        t_resync();
        t_special();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule